// File: doc/BRIEF.md
# Pointer-Linked Tag and Data Cache Store

This block is the storage core of a cache whose tags and data slots are decoupled. Every tag entry carries a forward pointer naming an arbitrary data slot, and every data slot carries a reverse pointer naming the tag that owns it. The tag side has more entries than the data side: two skews of indexed sets with several tag ways each. The data side is a pool of slots arranged as data sets of 16 ways. Set indices for both skews, and the skew chosen for an install, come in from outside the block. The block does not hash addresses and does not choose skews.

A request carries a line tag, a security-domain ID, a read/install flag, a target skew and one set index per skew. The block registers the request and matches tags in the next cycle. One edge later it returns hit or miss with the data-slot index. When an install misses, the block takes the lowest free tag way in the target set. It then frees a data slot chosen by a pseudo-random generator from the whole pool, and invalidates that slot's previous owner through the reverse pointer. If the target set has no free way, the block falls back to replacing way 0 of that set, and it flags the event as set-local.

Top module: `idc_store`

## Requirements
- R1: A request presented at clock edge E is answered with `rsp_valid` high for exactly the cycle after edge E+1. The request hits only if a valid tag in the indexed set of either skew matches both `req_tag` and `req_dom`. The set index for skew k is `req_sets[k*3 +: 3]`.
- R2: On a hit, `rsp_slot` equals the stored forward pointer of the matching tag. Bits [5:4] of `rsp_slot` select the data set. `rsp_way_oh` is the one-hot decode of bits [3:0], with bit n set for way n.
- R3: A miss with `req_install` low reports `rsp_hit` low, reports no eviction and changes no state, so a repeated lookup of the same line also misses.
- R4: An install that misses while the target set (skew `req_skew`) has a free way writes the line into the lowest-numbered free way. The line takes the data slot equal to the low 6 bits of the generator state, and the generator advances one step. `rsp_slot` reports that slot.
- R5: If the slot chosen in R4 already belongs to a line, that line's tag is invalidated. An eviction is reported with `evict_valid` high, `evict_sae` low, and the old line's tag, domain and slot. A later lookup of that line misses. If the slot was unowned, no eviction is reported.
- R6: An install that misses while all ways of the target set are valid replaces way 0 of that set and reuses its data slot. It reports an eviction with `evict_sae` high and the old line's tag and domain. The generator does not advance.
- R7: The generator is a 16-bit shift register that shifts left and feeds in bit15^bit13^bit12^bit10. It resets to 16'hACE1. A pulse on `seed_load` loads `seed_value`, or 16'h0001 if that value is zero, and the next install uses the loaded state.
- R8: After reset no tag is valid, every lookup misses, and `rsp_valid` and `evict_valid` are low.
- R9: An install request that hits behaves as a hit. It returns the stored slot and evicts and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load the generator with `seed_value` |
| seed_value | input | 16 | Generator seed |
| req_valid | input | 1 | Request strobe |
| req_install | input | 1 | 1: install on miss, 0: lookup only |
| req_tag | input | 20 | Line address tag |
| req_dom | input | 8 | Security-domain ID |
| req_skew | input | 1 | Skew that receives an install |
| req_sets | input | 6 | Set index per skew, skew 0 in the low bits |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Request hit |
| rsp_slot | output | 6 | Data slot of the hit or of the new line |
| rsp_way_oh | output | 16 | One-hot data way on a hit |
| evict_valid | output | 1 | A resident line was removed |
| evict_sae | output | 1 | The removal was set-local (target set full) |
| evict_slot | output | 6 | Data slot that was freed and reused |
| evict_tag | output | 20 | Tag of the removed line |
| evict_dom | output | 8 | Domain of the removed line |

## Verification
Every result is due exactly two edges after the request edge. The first edge registers the request, and the tag match, the state update and the response register all act on the second edge. The bench therefore drives each request on a falling edge, drops the strobe on the next falling edge, and samples on the falling edge after that, when the response and eviction report are both stable. A seed load takes effect at the single edge that samples it, so the following install sees the new state. The bench's own shift-register model and tag/slot model predict every slot number and every eviction.

// File: rtl/idc_pkg.sv
package idc_pkg;
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_GLOBAL = 2'd1,
      ACT_LOCAL  = 2'd2
   } idc_act_e;
endpackage

// File: rtl/idc_lfsr.sv
module idc_lfsr #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   INIT = W'(16'hACE1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] state
);
   logic fb;

   if (W == 16) begin : g_w16
      assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];
   end else if (W == 32) begin : g_w32
      assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];
   end else begin : g_bad
      $error("idc_lfsr: unsupported width");
      assign fb = 1'b0;
   end

   if (INIT == '0) begin : g_bad_init
      $error("idc_lfsr: zero initial state");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= INIT;
      else if (load)
         state <= (load_val == '0) ? W'(1) : load_val;
      else if (step)
         state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/idc_rev_map.sv
module idc_rev_map #(
   parameter int SLOTS  = 64,
   parameter int SK_W   = 1,
   parameter int SET_W  = 3,
   parameter int WAY_W  = 3,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_valid,
   output logic [SK_W-1:0]   rd_sk,
   output logic [SET_W-1:0]  rd_set,
   output logic [WAY_W-1:0]  rd_way,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [SK_W-1:0]   wr_sk,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [WAY_W-1:0]  wr_way
);
   logic             own_v   [SLOTS];
   logic [SK_W-1:0]  own_sk  [SLOTS];
   logic [SET_W-1:0] own_set [SLOTS];
   logic [WAY_W-1:0] own_way [SLOTS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) own_v[i] <= 1'b0;
      end else if (wr_en) begin
         own_v[wr_slot]   <= 1'b1;
         own_sk[wr_slot]  <= wr_sk;
         own_set[wr_slot] <= wr_set;
         own_way[wr_slot] <= wr_way;
      end
   end

   assign rd_valid = own_v[rd_slot];
   assign rd_sk    = own_sk[rd_slot];
   assign rd_set   = own_set[rd_slot];
   assign rd_way   = own_way[rd_slot];
endmodule

// File: rtl/idc_tag_store.sv
module idc_tag_store #(
   parameter int SKEWS  = 2,
   parameter int SETS   = 8,
   parameter int TWAYS  = 6,
   parameter int TAG_W  = 20,
   parameter int DOM_W  = 8,
   parameter int PTR_W  = 6,
   localparam int SK_W  = (SKEWS > 1) ? $clog2(SKEWS) : 1,
   localparam int SET_W = (SETS  > 1) ? $clog2(SETS)  : 1,
   localparam int WAY_W = (TWAYS > 1) ? $clog2(TWAYS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SKEWS*SET_W-1:0] lk_sets,
   input  logic [TAG_W-1:0]       lk_tag,
   input  logic [DOM_W-1:0]       lk_dom,
   input  logic [SK_W-1:0]        tgt_skew,
   output logic                   hit,
   output logic [PTR_W-1:0]       hit_fptr,
   output logic                   free_found,
   output logic [WAY_W-1:0]       free_way,
   output logic [TAG_W-1:0]       w0_tag,
   output logic [DOM_W-1:0]       w0_dom,
   output logic [PTR_W-1:0]       w0_fptr,
   input  logic [SK_W-1:0]        own_sk,
   input  logic [SET_W-1:0]       own_set,
   input  logic [WAY_W-1:0]       own_way,
   output logic [TAG_W-1:0]       own_tag,
   output logic [DOM_W-1:0]       own_dom,
   input  logic                   inv_en,
   input  logic                   wr_en,
   input  logic [SK_W-1:0]        wr_sk,
   input  logic [SET_W-1:0]       wr_set,
   input  logic [WAY_W-1:0]       wr_way,
   input  logic [PTR_W-1:0]       wr_fptr
);
   logic             v_q    [SKEWS][SETS][TWAYS];
   logic [TAG_W-1:0] tag_q  [SKEWS][SETS][TWAYS];
   logic [DOM_W-1:0] dom_q  [SKEWS][SETS][TWAYS];
   logic [PTR_W-1:0] fptr_q [SKEWS][SETS][TWAYS];

   logic [SET_W-1:0] lk_set [SKEWS];
   logic [SET_W-1:0] tgt_set;

   for (genvar g = 0; g < SKEWS; g++) begin : g_idx
      assign lk_set[g] = lk_sets[g*SET_W +: SET_W];
   end

   assign tgt_set = lk_set[tgt_skew];

   always_comb begin
      hit      = 1'b0;
      hit_fptr = '0;
      for (int k = 0; k < SKEWS; k++) begin
         for (int w = 0; w < TWAYS; w++) begin
            if (v_q[k][lk_set[k]][w] && tag_q[k][lk_set[k]][w] == lk_tag &&
                dom_q[k][lk_set[k]][w] == lk_dom) begin
               hit      = 1'b1;
               hit_fptr = fptr_q[k][lk_set[k]][w];
            end
         end
      end
   end

   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = TWAYS - 1; w >= 0; w--) begin
         if (!v_q[tgt_skew][tgt_set][w]) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
   end

   assign w0_tag  = tag_q[tgt_skew][tgt_set][0];
   assign w0_dom  = dom_q[tgt_skew][tgt_set][0];
   assign w0_fptr = fptr_q[tgt_skew][tgt_set][0];
   assign own_tag = tag_q[own_sk][own_set][own_way];
   assign own_dom = dom_q[own_sk][own_set][own_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SKEWS; k++)
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < TWAYS; w++)
                  v_q[k][s][w] <= 1'b0;
      end else begin
         if (inv_en) v_q[own_sk][own_set][own_way] <= 1'b0;
         if (wr_en) begin
            v_q[wr_sk][wr_set][wr_way]    <= 1'b1;
            tag_q[wr_sk][wr_set][wr_way]  <= lk_tag;
            dom_q[wr_sk][wr_set][wr_way]  <= lk_dom;
            fptr_q[wr_sk][wr_set][wr_way] <= wr_fptr;
         end
      end
   end
endmodule

// File: rtl/idc_store.sv
module idc_store #(
   parameter int           SKEWS     = 2,
   parameter int           SETS      = 8,
   parameter int           TWAYS     = 6,
   parameter int           DSETS     = 4,
   parameter int           DWAYS     = 16,
   parameter int           TAG_W     = 20,
   parameter int           DOM_W     = 8,
   parameter int           LFSR_W    = 16,
   parameter logic [15:0]  LFSR_INIT = 16'hACE1,
   localparam int SK_W   = (SKEWS > 1) ? $clog2(SKEWS) : 1,
   localparam int SET_W  = (SETS  > 1) ? $clog2(SETS)  : 1,
   localparam int WAY_W  = (TWAYS > 1) ? $clog2(TWAYS) : 1,
   localparam int SLOTS  = DSETS * DWAYS,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int DW_W   = $clog2(DWAYS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   seed_load,
   input  logic [LFSR_W-1:0]      seed_value,
   input  logic                   req_valid,
   input  logic                   req_install,
   input  logic [TAG_W-1:0]       req_tag,
   input  logic [DOM_W-1:0]       req_dom,
   input  logic [SK_W-1:0]        req_skew,
   input  logic [SKEWS*SET_W-1:0] req_sets,
   output logic                   rsp_valid,
   output logic                   rsp_hit,
   output logic [SLOT_W-1:0]      rsp_slot,
   output logic [DWAYS-1:0]       rsp_way_oh,
   output logic                   evict_valid,
   output logic                   evict_sae,
   output logic [SLOT_W-1:0]      evict_slot,
   output logic [TAG_W-1:0]       evict_tag,
   output logic [DOM_W-1:0]       evict_dom
);
   import idc_pkg::*;

   if (DWAYS != (1 << DW_W) || DSETS != (1 << $clog2(DSETS))) begin : g_bad_dsize
      $error("idc_store: data sets and ways must be powers of two");
   end
   if (SLOT_W > LFSR_W) begin : g_bad_lfsr
      $error("idc_store: generator narrower than slot index");
   end
   if (SLOTS >= SKEWS * SETS * TWAYS) begin : g_bad_ratio
      $error("idc_store: data pool must be smaller than the tag store");
   end

   // request stage
   logic                   st_v, st_inst;
   logic [TAG_W-1:0]       st_tag;
   logic [DOM_W-1:0]       st_dom;
   logic [SK_W-1:0]        st_skew;
   logic [SKEWS*SET_W-1:0] st_sets;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v    <= 1'b0;
         st_inst <= 1'b0;
      end else begin
         st_v    <= req_valid;
         st_inst <= req_install;
      end
      st_tag  <= req_tag;
      st_dom  <= req_dom;
      st_skew <= req_skew;
      st_sets <= req_sets;
   end

   logic              hit, free_found, own_v;
   logic [SLOT_W-1:0] hit_fptr, w0_fptr, victim, new_slot;
   logic [WAY_W-1:0]  free_way, own_way, wr_way;
   logic [TAG_W-1:0]  w0_tag, own_tag;
   logic [DOM_W-1:0]  w0_dom, own_dom;
   logic [SK_W-1:0]   own_sk;
   logic [SET_W-1:0]  own_set, tgt_set;
   logic [LFSR_W-1:0] lfsr_q;
   idc_act_e          act;

   assign tgt_set = st_sets[st_skew*SET_W +: SET_W];
   assign victim  = lfsr_q[SLOT_W-1:0];

   always_comb begin
      act = ACT_NONE;
      if (st_v && st_inst && !hit)
         act = free_found ? ACT_GLOBAL : ACT_LOCAL;
   end

   assign new_slot = (act == ACT_GLOBAL) ? victim : w0_fptr;
   assign wr_way   = (act == ACT_GLOBAL) ? free_way : '0;

   idc_tag_store #(
      .SKEWS(SKEWS), .SETS(SETS), .TWAYS(TWAYS),
      .TAG_W(TAG_W), .DOM_W(DOM_W), .PTR_W(SLOT_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_sets    (st_sets),
      .lk_tag     (st_tag),
      .lk_dom     (st_dom),
      .tgt_skew   (st_skew),
      .hit        (hit),
      .hit_fptr   (hit_fptr),
      .free_found (free_found),
      .free_way   (free_way),
      .w0_tag     (w0_tag),
      .w0_dom     (w0_dom),
      .w0_fptr    (w0_fptr),
      .own_sk     (own_sk),
      .own_set    (own_set),
      .own_way    (own_way),
      .own_tag    (own_tag),
      .own_dom    (own_dom),
      .inv_en     (act == ACT_GLOBAL && own_v),
      .wr_en      (act != ACT_NONE),
      .wr_sk      (st_skew),
      .wr_set     (tgt_set),
      .wr_way     (wr_way),
      .wr_fptr    (new_slot)
   );

   idc_rev_map #(
      .SLOTS(SLOTS), .SK_W(SK_W), .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_rev (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_slot  (victim),
      .rd_valid (own_v),
      .rd_sk    (own_sk),
      .rd_set   (own_set),
      .rd_way   (own_way),
      .wr_en    (act != ACT_NONE),
      .wr_slot  (new_slot),
      .wr_sk    (st_skew),
      .wr_set   (tgt_set),
      .wr_way   (wr_way)
   );

   idc_lfsr #(.W(LFSR_W), .INIT(LFSR_W'(LFSR_INIT))) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seed_load),
      .load_val (seed_value),
      .step     (act == ACT_GLOBAL),
      .state    (lfsr_q)
   );

   // response
   logic [SLOT_W-1:0] slot_c;
   logic [DWAYS-1:0]  oh_c;

   assign slot_c = hit ? hit_fptr : ((act != ACT_NONE) ? new_slot : '0);

   for (genvar d = 0; d < DWAYS; d++) begin : g_dec
      assign oh_c[d] = hit && (slot_c[DW_W-1:0] == DW_W'(d));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_slot    <= '0;
         rsp_way_oh  <= '0;
         evict_valid <= 1'b0;
         evict_sae   <= 1'b0;
         evict_slot  <= '0;
         evict_tag   <= '0;
         evict_dom   <= '0;
      end else begin
         rsp_valid   <= st_v;
         rsp_hit     <= st_v && hit;
         rsp_slot    <= slot_c;
         rsp_way_oh  <= oh_c;
         evict_valid <= (act == ACT_LOCAL) || (act == ACT_GLOBAL && own_v);
         evict_sae   <= (act == ACT_LOCAL);
         evict_slot  <= new_slot;
         evict_tag   <= (act == ACT_LOCAL) ? w0_tag : own_tag;
         evict_dom   <= (act == ACT_LOCAL) ? w0_dom : own_dom;
      end
   end
endmodule

// File: rtl/idc_store_chk.sv
module idc_store_chk #(
   parameter int DWAYS  = 16,
   parameter int LFSR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seed_load,
   input logic              req_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [DWAYS-1:0]  rsp_way_oh,
   input logic              evict_valid,
   input logic              evict_sae,
   input logic [LFSR_W-1:0] lfsr_q
);
   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ##1 rsp_valid); // R1
   AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> $countones(rsp_way_oh) == 1); // R2
   AST_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> (rsp_valid && !rsp_hit)); // R5
   AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> !evict_valid); // R9
   AST_SAE_IS_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
      evict_sae |-> evict_valid); // R6
   AST_SAE_HOLDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_sae && !$past(seed_load)) |-> $stable(lfsr_q)); // R6
   AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0); // R7
endmodule

bind idc_store idc_store_chk #(.DWAYS(DWAYS), .LFSR_W(LFSR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seed_load   (seed_load),
   .req_valid   (req_valid),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_way_oh  (rsp_way_oh),
   .evict_valid (evict_valid),
   .evict_sae   (evict_sae),
   .lfsr_q      (lfsr_q)
);

// File: tb/tb_idc_store.sv
module tb_idc_store;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [15:0] seed_value = '0;
   logic        req_valid = 1'b0, req_install = 1'b0;
   logic [19:0] req_tag = '0;
   logic [7:0]  req_dom = '0;
   logic        req_skew = 1'b0;
   logic [5:0]  req_sets = '0;
   logic        rsp_valid, rsp_hit, evict_valid, evict_sae;
   logic [5:0]  rsp_slot, evict_slot;
   logic [15:0] rsp_way_oh;
   logic [19:0] evict_tag;
   logic [7:0]  evict_dom;

   always #5 clk = ~clk;

   idc_store dut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
      .req_valid(req_valid), .req_install(req_install), .req_tag(req_tag),
      .req_dom(req_dom), .req_skew(req_skew), .req_sets(req_sets),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot),
      .rsp_way_oh(rsp_way_oh), .evict_valid(evict_valid), .evict_sae(evict_sae),
      .evict_slot(evict_slot), .evict_tag(evict_tag), .evict_dom(evict_dom)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   int next_tag = 20'h100;

   // reference model
   bit          mv [2][8][6];
   logic [19:0] mt [2][8][6];
   logic [7:0]  md [2][8][6];
   logic [5:0]  mf [2][8][6];
   bit          rv [64];
   int          rk [64], rs [64], rw [64];
   logic [15:0] ml = 16'hACE1;

   // last sampled results
   bit          a_hit, a_ev, a_sae;
   logic [5:0]  a_slot;
   logic [19:0] a_etag;

   function automatic logic [15:0] gen_next(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic req(input bit inst, input logic [19:0] t, input logic [7:0] d,
                      input bit sk, input int s0, input int s1, input string rq);
      bit e_hit = 0, e_ev = 0, e_sae = 0;
      logic [5:0] e_slot = '0, e_eslot = '0;
      logic [19:0] e_etag = '0;
      logic [7:0] e_edom = '0;
      int ts, fw;
      for (int w = 0; w < 6; w++) begin
         if (mv[0][s0][w] && mt[0][s0][w] == t && md[0][s0][w] == d) begin e_hit = 1; e_slot = mf[0][s0][w]; end
         if (mv[1][s1][w] && mt[1][s1][w] == t && md[1][s1][w] == d) begin e_hit = 1; e_slot = mf[1][s1][w]; end
      end
      if (!e_hit && inst) begin
         ts = sk ? s1 : s0;
         fw = -1;
         for (int w = 5; w >= 0; w--) if (!mv[sk][ts][w]) fw = w;
         if (fw >= 0) begin
            e_slot = ml[5:0];
            if (rv[e_slot]) begin
               e_ev = 1; e_eslot = e_slot;
               e_etag = mt[rk[e_slot]][rs[e_slot]][rw[e_slot]];
               e_edom = md[rk[e_slot]][rs[e_slot]][rw[e_slot]];
               mv[rk[e_slot]][rs[e_slot]][rw[e_slot]] = 0;
            end
            ml = gen_next(ml);
         end else begin
            fw = 0;
            e_slot = mf[sk][ts][0];
            e_ev = 1; e_sae = 1; e_eslot = e_slot;
            e_etag = mt[sk][ts][0];
            e_edom = md[sk][ts][0];
         end
         mv[sk][ts][fw] = 1; mt[sk][ts][fw] = t; md[sk][ts][fw] = d; mf[sk][ts][fw] = e_slot;
         rv[e_slot] = 1; rk[e_slot] = sk; rs[e_slot] = ts; rw[e_slot] = fw;
      end
      @(negedge clk);
      req_valid = 1; req_install = inst; req_tag = t; req_dom = d;
      req_skew = sk; req_sets = {3'(s1), 3'(s0)};
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      a_hit = rsp_hit; a_ev = evict_valid; a_sae = evict_sae; a_slot = rsp_slot; a_etag = evict_tag;
      chk(rq, "rsp_valid", rsp_valid, 1);
      chk(rq, "rsp_hit", rsp_hit, e_hit);
      if (e_hit || inst) chk(rq, "rsp_slot", rsp_slot, e_slot);
      if (e_hit) chk("R2", "rsp_way_oh", rsp_way_oh, 16'(1) << e_slot[3:0]);
      chk(rq, "evict_valid", evict_valid, e_ev);
      if (e_ev) begin
         chk(rq, "evict_sae", evict_sae, e_sae);
         chk(rq, "evict_tag", evict_tag, e_etag);
         chk(rq, "evict_dom", evict_dom, e_edom);
         chk(rq, "evict_slot", evict_slot, e_eslot);
      end
      @(negedge clk);
      chk("R1", "rsp_valid pulse", rsp_valid, 0);
   endtask

   task automatic load_seed(input logic [15:0] s);
      @(negedge clk);
      seed_load = 1; seed_value = s;
      @(negedge clk);
      seed_load = 0;
      ml = (s == 0) ? 16'h0001 : s;
   endtask

   task automatic t_reset;
      chk("R8", "rsp_valid after reset", rsp_valid, 0);
      chk("R8", "evict_valid after reset", evict_valid, 0);
      req(0, 20'h00055, 8'h01, 0, 2, 6, "R8");
      chk("R8", "empty lookup misses", a_hit, 0);
   endtask

   task automatic t_read_miss;
      req(0, 20'h00777, 8'h03, 1, 4, 4, "R3");
      req(0, 20'h00777, 8'h03, 1, 4, 4, "R3");
      chk("R3", "repeat read still misses", a_hit, 0);
      chk("R3", "read miss no eviction", a_ev, 0);
   endtask

   task automatic t_install_basic;
      logic [5:0] s;
      req(1, 20'h0A0A0, 8'h11, 0, 3, 1, "R4");
      chk("R4", "first slot from generator", a_slot, 6'(16'hACE1));
      s = a_slot;
      req(0, 20'h0A0A0, 8'h11, 0, 3, 1, "R1");
      chk("R2", "hit slot = pointer", a_slot, s);
      req(0, 20'h0A0A0, 8'h12, 0, 3, 1, "R1");
      chk("R1", "other domain misses", a_hit, 0);
      req(0, 20'h0A0A1, 8'h11, 0, 3, 1, "R1");
      chk("R1", "other tag misses", a_hit, 0);
   endtask

   task automatic t_other_skew;
      req(1, 20'h0B0B0, 8'h22, 1, 0, 6, "R4");
      req(0, 20'h0B0B0, 8'h22, 0, 0, 6, "R1");
      chk("R1", "skew1 line hits", a_hit, 1);
   endtask

   task automatic t_dup_install;
      req(1, 20'h0B0B0, 8'h22, 0, 0, 6, "R9");
      chk("R9", "install of resident line hits", a_hit, 1);
      chk("R9", "no eviction on hit", a_ev, 0);
   endtask

   task automatic t_seed;
      load_seed(16'h3A15);
      req(1, 20'h0C001, 8'h05, 0, 5, 5, "R7");
      chk("R7", "slot after seed", a_slot, 6'h15);
      load_seed(16'h0000);
      req(1, 20'h0C002, 8'h05, 1, 5, 2, "R7");
      chk("R7", "zero seed maps to one", a_slot, 6'h01);
   endtask

   task automatic t_global_evict;
      logic [5:0] xs;
      req(1, 20'h0D00D, 8'h44, 0, 0, 0, "R4");
      xs = a_slot;
      load_seed({10'h2C0, xs});
      req(1, 20'h0E00E, 8'h45, 1, 2, 7, "R5");
      chk("R5", "victim owner reported", a_ev, 1);
      chk("R5", "global not set-local", a_sae, 0);
      chk("R5", "evicted tag", a_etag, 20'h0D00D);
      req(0, 20'h0D00D, 8'h44, 0, 0, 0, "R5");
      chk("R5", "evicted line misses", a_hit, 0);
   endtask

   task automatic t_sae;
      logic [19:0] w0t;
      int tries = 0;
      bit full;
      do begin
         full = 1;
         for (int w = 0; w < 6; w++) if (!mv[1][5][w]) full = 0;
         if (!full) begin
            req(1, 20'(next_tag), 8'h66, 1, 1, 5, "R4");
            next_tag++;
         end
         tries++;
      end while (!full && tries < 40);
      chk("R6", "set filled", full, 1);
      w0t = mt[1][5][0];
      req(1, 20'(next_tag), 8'h66, 1, 1, 5, "R6");
      next_tag++;
      chk("R6", "set-local eviction flagged", a_sae, 1);
      chk("R6", "way 0 line evicted", a_etag, w0t);
      req(0, w0t, 8'h66, 0, 1, 5, "R6");
      chk("R6", "old way 0 line misses", a_hit, 0);
      req(1, 20'(next_tag), 8'h67, 0, 6, 3, "R6");
      next_tag++;
   endtask

   task automatic t_fill;
      for (int i = 0; i < 150; i++) begin
         req(1, 20'(next_tag), 8'(i % 3), 1'(i % 2), (i * 3) % 8, (i * 5) % 8, "R5");
         next_tag++;
         if (i % 10 == 0) req(0, 20'(next_tag - 1), 8'(i % 3), 0, (i * 3) % 8, (i * 5) % 8, "R1");
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_read_miss();
      t_install_basic();
      t_other_skew();
      t_dup_install();
      t_seed();
      t_global_evict();
      t_sae();
      t_fill();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule